// File: doc/BRIEF.md
# UART Channel with Remote Loopback Echo

This block is one serial channel with a receiver, a small local transmitter and a remote loopback path. In remote loopback the receiver samples each incoming bit at mid-bit on a 16x tick and sends it straight back out on the transmit line. Every bit is held for one bit period. Parity and stop bits go back exactly as they arrived, and none of them is recomputed. A break (a character whose bits are all low) keeps the outgoing line low until the receiver validates a fresh start bit. While this mode is active the CPU side sees no received data and no error flags. The far end can therefore test the whole link without any software involvement.

In normal mode a completed character is placed in a holding register with a ready flag and parity and framing flags. The CPU clears the ready flag with a one-cycle acknowledge. The transmit line then carries only the local transmitter. The character format is shared by both paths and is set on static configuration pins: 5 to 8 data bits, optional even or odd parity, and one or two stop bits. The 16x tick comes from a fixed clock divisor.

Top module: `uart_rl_echo`

## Requirements
- R1: After reset `txd` is high, `rd_valid`, `err_parity`, `err_frame` and `tx_busy` are low.
- R2: A low level on `rxd` starts a character only if the line is still low at the 8th tick after it was first seen. A shorter low pulse leaves the receiver idle and, in remote loopback, leaves `txd` high.
- R3: With `rloop_en` and `rx_en` high, each received bit (start, data LSB first, parity, stops) appears on `txd` from its mid-bit sample for one bit period (16 ticks). After a character whose stop bits are high, `txd` returns to high.
- R4: In remote loopback, parity and stop bits are echoed with the values received, including a wrong parity bit or a low stop bit. The echo of the last stop bit lasts 16 ticks, after which `txd` marks.
- R5: In remote loopback, received characters do not set `rd_valid` and do not change `rd_data`, `err_parity` or `err_frame`.
- R6: A character whose start, data, parity and stop bits are all low is a break. In remote loopback `txd` then stays low, even after `rxd` returns high, until the next valid start bit. The receiver re-arms only after it sees `rxd` high.
- R7: With `rx_en` low the receiver stays idle. In remote loopback `txd` stays high, and in normal mode `rd_valid` is not set.
- R8: `cfg_dbits` selects the data width: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. `cfg_par_en` adds a parity bit, `cfg_par_odd` selects odd parity, and `cfg_stop2` selects two stop bits. Bits of `rd_data` above the data width read 0.
- R9: In normal mode a completed character is loaded into `rd_data` and sets `rd_valid` one clock after the last stop-bit sample. `rd_ack` clears `rd_valid`.
- R10: In normal mode `err_parity` is set when parity is enabled and the count of ones over the data bits and the parity bit is odd for even parity (or even for odd parity). `err_frame` is set when any stop bit is sampled low. Both flags are replaced with each new character.
- R11: In normal mode a `tx_load` pulse while `tx_busy` is low sends `tx_byte` on `txd` as start bit, data LSB first, parity and stop bits in the configured format, 16 ticks per bit. `tx_busy` is high from the load until the last stop bit ends.
- R12: In remote loopback `tx_load` is ignored and `tx_busy` stays low.
- R13: In normal mode `txd` is driven only by the local transmitter. It is high whenever `tx_busy` is low, including while a character is being received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| rloop_en | input | 1 | 1 = remote loopback, 0 = normal |
| cfg_dbits | input | 2 | Data width code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rd_data | output | 8 | Received character |
| rd_valid | output | 1 | Received character ready |
| rd_ack | input | 1 | Clears `rd_valid` |
| err_parity | output | 1 | Parity mismatch on the held character |
| err_frame | output | 1 | Low stop bit on the held character |
| tx_load | input | 1 | Start local transmission |
| tx_byte | input | 8 | Character to send |
| tx_busy | output | 1 | Local transmitter active |

## Verification
A wrong bit counter or sampling phase shows on `txd` within one bit period: the echoed bit seen at the end of each driven bit no longer matches the bit just sent. A break flag that is not set, or one that is never cleared, shows as `txd` rising during the high gap after a break, or staying low through the character that follows. A loopback gate that leaks shows one clock after the last stop sample as a rise of `rd_valid` or a change of a flag. A mis-sized transmit frame shows as a wrong level at some bit midpoint, or as `tx_busy` still high one bit time after the expected end.

// File: rtl/uart_rl_pkg.sv
package uart_rl_pkg;
  localparam int MAXB = 8;            // widest character
  localparam int FW   = MAXB + 4;     // start + data + parity + two stops
  localparam int LW   = 4;            // width of bit counts

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI
  } rx_st_t;

  typedef struct packed {
    logic [1:0] dbits;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } fmt_t;

  function automatic logic [LW-1:0] data_len(input logic [1:0] code);
    return LW'(5) + {2'b00, code};
  endfunction

  // value the parity bit must take for the given data and sense
  function automatic logic par_bit(input logic [MAXB-1:0] d, input logic [LW-1:0] len,
                                   input logic odd);
    logic acc;
    acc = odd;
    for (int i = 0; i < MAXB; i++)
      if (i < int'(len)) acc = acc ^ d[i];
    return acc;
  endfunction

  function automatic logic [FW-1:0] make_frame(input logic [MAXB-1:0] d, input fmt_t f);
    logic [FW-1:0]  v;
    logic [LW-1:0]  n;
    n = data_len(f.dbits);
    v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < MAXB; i++)
      if (i < int'(n)) v[i+1] = d[i];
    if (f.par_en) v[n + LW'(1)] = par_bit(d, n, f.par_odd);
    return v;
  endfunction

  function automatic logic [LW-1:0] frame_bits(input fmt_t f);
    return LW'(2) + data_len(f.dbits) + {3'b000, f.par_en} + {3'b000, f.stop2};
  endfunction
endpackage

// File: rtl/uart_rl_tick.sv
module uart_rl_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_every
      assign tick = rst_n;
    end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (cnt == CW'(DIV - 1)) cnt <= '0;
        else                          cnt <= cnt + CW'(1);
      end
      assign tick = (cnt == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/uart_rl_rx.sv
module uart_rl_rx
  import uart_rl_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rxd,
  input  logic            rx_en,
  input  logic [LW-1:0]   len,
  input  logic            par_en,
  input  logic            stop2,
  output logic            echo,
  output logic            done,
  output logic [MAXB-1:0] data,
  output logic            pbit,
  output logic            ferr
);
  localparam int SW = (SYNC < 1) ? 1 : SYNC;

  logic [SW-1:0] sq;
  logic          rx_s;
  generate
    if (SW == 1) begin : g_sync1
      always_ff @(posedge clk) sq <= !rst_n ? 1'b1 : rxd;
    end else begin : g_syncn
      always_ff @(posedge clk) sq <= !rst_n ? '1 : {sq[SW-2:0], rxd};
    end
  endgenerate
  assign rx_s = sq[SW-1];

  rx_st_t        st;
  logic [3:0]    cnt, mark_cnt;
  logic [LW-1:0] idx;
  logic          stop_n, allz, brk_hold, mark_pend;
  logic          mid, brk_now;

  assign mid     = tick && (cnt == 4'd15);
  assign brk_now = allz && !rx_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= RX_IDLE; cnt <= '0; idx <= '0; data <= '0; pbit <= 1'b0; ferr <= 1'b0;
      stop_n <= 1'b0; allz <= 1'b1; done <= 1'b0; echo <= 1'b1;
      brk_hold <= 1'b0; mark_pend <= 1'b0; mark_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (!rx_en) begin
        st <= RX_IDLE; echo <= 1'b1; brk_hold <= 1'b0; mark_pend <= 1'b0;
      end else if (tick) begin
        cnt <= cnt + 4'd1;
        // return to mark one bit time after the last stop echo
        if (mark_pend) begin
          mark_cnt <= mark_cnt + 4'd1;
          if (mark_cnt == 4'd15) begin echo <= 1'b1; mark_pend <= 1'b0; end
        end
        case (st)
          RX_IDLE: if (!rx_s) begin st <= RX_START; cnt <= '0; end
          RX_START: if (cnt == 4'd7) begin
            if (!rx_s) begin
              st <= RX_DATA; cnt <= '0; idx <= '0; data <= '0; allz <= 1'b1;
              ferr <= 1'b0; echo <= 1'b0; brk_hold <= 1'b0; mark_pend <= 1'b0;
            end else st <= RX_IDLE;
          end
          RX_DATA: if (mid) begin
            data[idx[2:0]] <= rx_s; echo <= rx_s; allz <= allz & !rx_s;
            idx <= idx + LW'(1); stop_n <= 1'b0;
            if (idx == len - LW'(1)) st <= par_en ? RX_PAR : RX_STOP;
          end
          RX_PAR: if (mid) begin
            pbit <= rx_s; echo <= rx_s; allz <= allz & !rx_s; st <= RX_STOP;
          end
          RX_STOP: if (mid) begin
            echo <= rx_s; ferr <= ferr | !rx_s;
            if (stop_n == stop2) begin
              done <= 1'b1; brk_hold <= brk_now; mark_pend <= !brk_now; mark_cnt <= '0;
              st <= brk_now ? RX_WAITHI : RX_IDLE;
            end else begin
              allz <= allz & !rx_s; stop_n <= 1'b1;
            end
          end
          RX_WAITHI: if (rx_s) st <= RX_IDLE;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st == RX_IDLE) && echo);
  p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hold |-> !echo);
endmodule

// File: rtl/uart_rl_tx.sv
module uart_rl_tx
  import uart_rl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            load,
  input  logic [MAXB-1:0] byte_in,
  input  fmt_t            fmt,
  output logic            txd,
  output logic            busy
);
  logic [FW-1:0] frame;
  logic [3:0]    cnt;
  logic [LW-1:0] rem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; frame <= '1; cnt <= '0; rem <= '0;
    end else if (load && !busy) begin
      busy <= 1'b1; frame <= make_frame(byte_in, fmt); cnt <= '0; rem <= frame_bits(fmt);
    end else if (busy && tick) begin
      cnt <= cnt + 4'd1;
      if (cnt == 4'd15) begin
        frame <= {1'b1, frame[FW-1:1]};
        rem   <= rem - LW'(1);
        if (rem == LW'(1)) busy <= 1'b0;
      end
    end
  end

  assign txd = busy ? frame[0] : 1'b1;
endmodule

// File: rtl/uart_rl_echo.sv
module uart_rl_echo
  import uart_rl_pkg::*;
#(
  parameter int DIV  = 4,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic            rloop_en,
  input  logic [1:0]      cfg_dbits,
  input  logic            cfg_par_en,
  input  logic            cfg_par_odd,
  input  logic            cfg_stop2,
  input  logic            rxd,
  output logic            txd,
  output logic [MAXB-1:0] rd_data,
  output logic            rd_valid,
  input  logic            rd_ack,
  output logic            err_parity,
  output logic            err_frame,
  input  logic            tx_load,
  input  logic [MAXB-1:0] tx_byte,
  output logic            tx_busy
);
  fmt_t            fmt;
  logic            tick, echo, rx_done, rx_pbit, rx_ferr, tx_line, tx_go, perr_now;
  logic [MAXB-1:0] rx_data;
  logic [LW-1:0]   rx_len;

  assign fmt    = '{dbits: cfg_dbits, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};
  assign rx_len = data_len(cfg_dbits);

  uart_rl_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  uart_rl_rx #(.SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_en(rx_en),
    .len(rx_len), .par_en(cfg_par_en), .stop2(cfg_stop2),
    .echo(echo), .done(rx_done), .data(rx_data), .pbit(rx_pbit), .ferr(rx_ferr));

  assign tx_go = tx_load && !rloop_en;

  uart_rl_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_go), .byte_in(tx_byte),
    .fmt(fmt), .txd(tx_line), .busy(tx_busy));

  assign txd      = rloop_en ? echo : tx_line;
  assign perr_now = cfg_par_en && (par_bit(rx_data, rx_len, cfg_par_odd) != rx_pbit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0; rd_valid <= 1'b0; err_parity <= 1'b0; err_frame <= 1'b0;
    end else if (rx_done && !rloop_en) begin
      rd_data <= rx_data; rd_valid <= 1'b1; err_parity <= perr_now; err_frame <= rx_ferr;
    end else if (rd_ack) begin
      rd_valid <= 1'b0;
    end
  end

  p_cpu_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rloop_en) |-> !$rose(rd_valid));
  p_ignore_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rloop_en && !tx_busy |=> !tx_busy);
  p_mark_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rloop_en && !tx_busy |-> txd);
endmodule

// File: tb/uart_rl_echo_test.sv
module uart_rl_echo_test;
  localparam int DIV    = 4;
  localparam int BITCLK = 16 * DIV;

  logic clk = 1'b0;
  logic rst_n, rx_en, rloop_en, cfg_par_en, cfg_par_odd, cfg_stop2, rxd;
  logic rd_ack, tx_load;
  logic [1:0] cfg_dbits;
  logic [7:0] tx_byte, rd_data;
  logic txd, rd_valid, err_parity, err_frame, tx_busy;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic exp_q[$];

  always #4 clk = ~clk;

  uart_rl_echo #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rloop_en(rloop_en),
    .cfg_dbits(cfg_dbits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .rxd(rxd), .txd(txd), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ack(rd_ack), .err_parity(err_parity),
    .err_frame(err_frame), .tx_load(tx_load), .tx_byte(tx_byte), .tx_busy(tx_busy));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_fmt(input logic [1:0] d, input bit pe, input bit po, input bit s2);
    cfg_dbits = d; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
  endtask

  // builds the bit sequence of one character, first bit in f[0]
  task automatic build(input logic [7:0] d, input int len, input bit pe, input bit po,
                       input bit s2, input bit flip, input bit st1,
                       output logic [15:0] f, output int n);
    int ones = 0;
    f = '1; n = 0;
    f[n] = 1'b0; n++;
    for (int i = 0; i < len; i++) begin f[n] = d[i]; ones += int'(d[i]); n++; end
    if (pe) begin f[n] = logic'(ones % 2) ^ po ^ flip; n++; end
    f[n] = st1; n++;
    if (s2) begin f[n] = 1'b1; n++; end
  endtask

  // mode 0: no check, 1: echo compare, 2: line must mark
  task automatic send(input logic [15:0] f, input int n, input int mode, input string tag);
    for (int k = 0; k < n; k++) begin
      rxd = f[k];
      if (mode == 1) exp_q.push_back(f[k]);
      repeat (BITCLK) @(negedge clk);
      if (mode == 1) chk(tag, txd, exp_q.pop_front());
      else if (mode == 2) chk(tag, txd, 1);
    end
  endtask

  task automatic idle(input int nb);
    rxd = 1'b1;
    repeat (nb * BITCLK) @(negedge clk);
  endtask

  task automatic ack();
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
  endtask

  task automatic local_send(input logic [7:0] b, input int len, input bit pe, input bit po,
                            input bit s2, input string tag);
    logic [15:0] f; int n;
    build(b, len, pe, po, s2, 1'b0, 1'b1, f, n);
    tx_byte = b; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
    chk({tag, " busy"}, tx_busy, 1);
    repeat (8 * DIV - 1) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      chk(tag, txd, f[k]);
      repeat (BITCLK) @(negedge clk);
    end
    chk({tag, " done"}, tx_busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] f; int n; int bad;
    rst_n = 0; rx_en = 0; rloop_en = 0; rxd = 1; rd_ack = 0; tx_load = 0; tx_byte = 0;
    set_fmt(2'd3, 0, 0, 0);
    repeat (5) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R1 txd", txd, 1); chk("R1 rd_valid", rd_valid, 0);
    chk("R1 err_parity", err_parity, 0); chk("R1 err_frame", err_frame, 0);
    chk("R1 tx_busy", tx_busy, 0);

    // remote loopback
    rloop_en = 1; rx_en = 1; idle(1);
    build(8'hA5, 8, 0, 0, 0, 0, 1, f, n); send(f, n, 1, "R3 echo 8N1");
    idle(2); chk("R3 mark after char", txd, 1); chk("R5 no rd_valid", rd_valid, 0);

    set_fmt(2'd2, 1, 0, 1);
    build(8'h35, 7, 1, 0, 1, 1, 1, f, n); send(f, n, 1, "R4 R8 bad parity echoed 7E2");
    idle(2); chk("R5 no parity flag", err_parity, 0); chk("R5 no rd_valid", rd_valid, 0);

    set_fmt(2'd3, 0, 0, 1);
    build(8'h81, 8, 0, 0, 1, 0, 0, f, n); send(f, n, 1, "R4 low stop echoed");
    idle(2); chk("R4 mark after stop echo", txd, 1); chk("R5 no frame flag", err_frame, 0);

    // break, then high gap, then a new character
    set_fmt(2'd3, 0, 0, 0);
    rxd = 1'b0;
    for (int k = 0; k < 14; k++) begin
      repeat (BITCLK) @(negedge clk);
      if (k >= 10) chk("R6 break echoed", txd, 0);
    end
    rxd = 1'b1;
    for (int k = 0; k < 3; k++) begin
      repeat (BITCLK) @(negedge clk);
      chk("R6 break held through high gap", txd, 0);
    end
    build(8'h5A, 8, 0, 0, 0, 0, 1, f, n); send(f, n, 1, "R6 echo after break");
    idle(2); chk("R6 mark after break ends", txd, 1);

    // short low pulse
    rxd = 1'b0; repeat (4 * DIV) @(negedge clk); rxd = 1'b1;
    bad = 0;
    for (int k = 0; k < 2 * BITCLK; k++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    chk("R2 short pulse no echo", bad, 0);

    // receiver disabled in loopback
    rx_en = 0;
    build(8'h00, 8, 0, 0, 0, 0, 1, f, n); send(f, n, 2, "R7 no echo when disabled");
    rx_en = 1; idle(1);

    tx_byte = 8'hC3; tx_load = 1; @(negedge clk); tx_load = 0;
    repeat (3) @(negedge clk);
    chk("R12 load ignored busy", tx_busy, 0); chk("R12 load ignored txd", txd, 1);

    // normal mode
    rloop_en = 0; idle(1);
    build(8'h3C, 8, 0, 0, 0, 0, 1, f, n); send(f, n, 2, "R13 txd marks while receiving");
    chk("R9 rd_valid", rd_valid, 1); chk("R9 rd_data", rd_data, 8'h3C);
    chk("R10 no parity err", err_parity, 0); chk("R10 no frame err", err_frame, 0);
    ack(); chk("R9 ack clears", rd_valid, 0);

    set_fmt(2'd0, 1, 1, 0);
    build(8'hFF, 5, 1, 1, 0, 0, 1, f, n); send(f, n, 0, "");
    chk("R8 5-bit data", rd_data, 8'h1F); chk("R10 odd parity ok", err_parity, 0);
    build(8'hFF, 5, 1, 1, 0, 1, 1, f, n); send(f, n, 0, "");
    chk("R10 parity err", err_parity, 1);

    set_fmt(2'd3, 0, 0, 1);
    build(8'h81, 8, 0, 0, 1, 0, 0, f, n); send(f, n, 0, "");
    chk("R10 frame err", err_frame, 1); chk("R8 8-bit data", rd_data, 8'h81);
    chk("R10 parity flag replaced", err_parity, 0);
    ack();

    rx_en = 0;
    build(8'h12, 8, 0, 0, 1, 0, 1, f, n); send(f, n, 0, "");
    chk("R7 no delivery when disabled", rd_valid, 0);
    rx_en = 1; idle(1);

    set_fmt(2'd3, 0, 0, 0);
    local_send(8'h55, 8, 0, 0, 0, "R11 tx 8N1");
    set_fmt(2'd2, 1, 1, 0);
    local_send(8'h2A, 7, 1, 1, 0, "R11 R8 tx 7O1");
    set_fmt(2'd1, 1, 0, 1);
    local_send(8'h2D, 6, 1, 0, 1, "R11 R8 tx 6E2");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule